// File: doc/BRIEF.md
# Reservation Monitor for Load-Reserved / Store-Conditional Atomics

This block tracks reservations on behalf of several cores that share one memory. A core issues a load-reserved to claim a word and later a store-conditional to the same word. The store-conditional is allowed to write memory only if nothing has written that word in the meantime. The block keeps one reservation per core, made of a valid flag and a word address. It watches a stream of write addresses from all ordinary stores into the shared memory. For each store-conditional it raises a write enable in the same cycle, which the memory uses to let the store through or to drop it.

Addresses are byte addresses, and reservations are kept at word granularity: bits [1:0] are ignored when addresses are compared. Each store-conditional produces a one-bit result on the next cycle. A result of 0 means the store was written, and 1 means it failed. When several events land in the same cycle, fixed ordering rules apply. An ordinary write counts as happening before any reservation check in that cycle. Among store-conditionals to one word, the lowest-numbered core wins. A load-reserved counts as happening after every write in its cycle.

Top module: `resv_monitor`

## Requirements
- R1: After reset, no core holds a reservation, `memWrEn` and `respValid` are 0, and a store-conditional from any core fails.
- R2: A store-conditional from core i succeeds under two conditions: core i holds a reservation whose word (address bits [ADDR_W-1:2]) equals that of the request, and no write to that word has been seen since. On success, `memWrEn[i]` is 1 in the request cycle, and in the next cycle `respValid[i]`=1 and `respStatus[i]`=0.
- R3: A failed store-conditional keeps `memWrEn[i]` at 0 in the request cycle. In the next cycle it gives `respValid[i]`=1 and `respStatus[i]`=1. `respValid[i]` is 1 exactly in the cycle after a store-conditional from core i.
- R4: A store-conditional fails when its core holds no reservation, or when its reservation is on a different word.
- R5: Every store-conditional clears its own core's reservation, whether it succeeds or fails, so a second store-conditional without a new load-reserved fails.
- R6: A valid observed write (`wrValid`=1) to a word clears every core's reservation on that word. A write to any other word leaves reservations intact.
- R7: An observed write in the same cycle as a store-conditional to the same word makes that store-conditional fail.
- R8: When several cores issue store-conditionals to the same word in one cycle, only the lowest-numbered core that would otherwise succeed commits, and the others fail. Store-conditionals to different words in one cycle are independent.
- R9: A committed store-conditional clears the reservations that other cores hold on the same word.
- R10: A new load-reserved from a core replaces that core's previous reservation.
- R11: A load-reserved is ordered after all writes and commits in its cycle, so its reservation survives them.
- R12: If a core raises `lrReq` and `scReq` together, the store-conditional is handled and the load-reserved is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lrReq | input | NUM_CORES | Per-core load-reserved strobe |
| scReq | input | NUM_CORES | Per-core store-conditional strobe |
| reqAddr | input | NUM_CORES*ADDR_W | Per-core byte address, core i in bits [i*ADDR_W +: ADDR_W] |
| wrValid | input | 1 | An ordinary write to shared memory is happening this cycle |
| wrAddr | input | ADDR_W | Byte address of that write |
| memWrEn | output | NUM_CORES | Combinational commit: the store-conditional of core i may write memory |
| respValid | output | NUM_CORES | Store-conditional result available, one cycle after the request |
| respStatus | output | NUM_CORES | 0 = success, 1 = failure; 0 when respValid is 0 |

## Verification
The assertions check on every cycle that a commit only follows a matching reservation and that no two cores commit to one word together. They also check that each result appears one cycle after its store-conditional and carries the inverse of the commit. Finally, they check that a store-conditional, a conflicting write or a load-reserved leaves the reservation state they require. Whether a reservation really survived several idle cycles, was replaced by a second load-reserved, or was killed by another core's commit shows only in the bench's scenarios. There a later store-conditional brings the hidden state out to `memWrEn` and the result ports. The bench compares those ports on every cycle against a behavioural model.

// File: rtl/resv_pkg.sv
package resv_pkg;

  // Strobes from the control to the datapath, one set per core.
  typedef struct packed {
    logic setRes;   // capture request word, mark valid
    logic clrRes;   // own reservation ends (store-conditional issued)
    logic commit;   // store-conditional writes memory this cycle
  } resStrobe_t;

endpackage

// File: rtl/resv_datapath.sv
module resv_datapath
  import resv_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CORES*ADDR_W-1:0]    reqAddr,
  input  logic                           wrValid,
  input  logic [ADDR_W-1:0]              wrAddr,
  input  resStrobe_t [NUM_CORES-1:0]     ctl,
  output logic [NUM_CORES-1:0]           scMatch,
  output logic [NUM_CORES-1:0]           extHit,
  output logic [NUM_CORES*NUM_CORES-1:0] sameWord
);

  localparam int OFS_W  = 2;
  localparam int WORD_W = ADDR_W - OFS_W;

  logic [WORD_W-1:0]    reqWord [NUM_CORES];
  logic [WORD_W-1:0]    resWord [NUM_CORES];
  logic [NUM_CORES-1:0] resValid;
  logic [NUM_CORES-1:0] commitKill;
  logic [WORD_W-1:0]    wrWord;
  logic                 unusedOffsets;

  assign wrWord = wrAddr[ADDR_W-1:OFS_W];

  always_comb begin
    unusedOffsets = ^wrAddr[OFS_W-1:0];
    for (int k = 0; k < NUM_CORES; k++) begin
      unusedOffsets = unusedOffsets ^ (^reqAddr[k*ADDR_W +: OFS_W]);
    end
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : gCore
    assign reqWord[g] = reqAddr[g*ADDR_W + OFS_W +: WORD_W];

    // Word match of this core's live reservation against its own request.
    assign scMatch[g] = resValid[g] && (resWord[g] == reqWord[g]);
    // Ordinary write landing on this core's reserved word.
    assign extHit[g]  = wrValid && resValid[g] && (resWord[g] == wrWord);

    // Any committed store-conditional landing on this core's reserved word.
    always_comb begin
      commitKill[g] = 1'b0;
      for (int j = 0; j < NUM_CORES; j++) begin
        if (ctl[j].commit && (reqWord[j] == resWord[g])) commitKill[g] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resValid[g] <= 1'b0;
        resWord[g]  <= '0;
      end else if (ctl[g].setRes) begin
        resValid[g] <= 1'b1;
        resWord[g]  <= reqWord[g];
      end else if (ctl[g].clrRes || extHit[g] || commitKill[g]) begin
        resValid[g] <= 1'b0;
      end
    end

    for (genvar h = 0; h < NUM_CORES; h++) begin : gPair
      assign sameWord[g*NUM_CORES + h] = (reqWord[g] == reqWord[h]);
    end

    AST_SC_CLEARS_OWN: assert property (@(posedge clk) disable iff (!rstN)
      ctl[g].clrRes |=> !resValid[g]); // R5
    AST_WRITE_KILLS: assert property (@(posedge clk) disable iff (!rstN)
      (extHit[g] && !ctl[g].setRes) |=> !resValid[g]); // R6
    AST_LR_CAPTURES: assert property (@(posedge clk) disable iff (!rstN)
      ctl[g].setRes |=> (resValid[g] && resWord[g] == $past(reqWord[g]))); // R10
    AST_PEER_COMMIT_KILLS: assert property (@(posedge clk) disable iff (!rstN)
      (resValid[g] && commitKill[g] && !ctl[g].setRes) |=> !resValid[g]); // R9
  end

endmodule

// File: rtl/resv_control.sv
module resv_control
  import resv_pkg::*;
#(
  parameter int NUM_CORES = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NUM_CORES-1:0]           lrReq,
  input  logic [NUM_CORES-1:0]           scReq,
  input  logic [NUM_CORES-1:0]           scMatch,
  input  logic [NUM_CORES-1:0]           extHit,
  input  logic [NUM_CORES*NUM_CORES-1:0] sameWord,
  output resStrobe_t [NUM_CORES-1:0]     ctl,
  output logic [NUM_CORES-1:0]           memWrEn,
  output logic [NUM_CORES-1:0]           respValid,
  output logic [NUM_CORES-1:0]           respStatus
);

  logic [NUM_CORES-1:0] scOk;
  logic [NUM_CORES-1:0] blocked;
  logic [NUM_CORES-1:0] commit;

  for (genvar i = 0; i < NUM_CORES; i++) begin : gDecide
    // Eligible: live matching reservation and no colliding write this cycle.
    assign scOk[i] = scReq[i] && scMatch[i] && !extHit[i];

    // A lower-numbered eligible core on the same word takes precedence.
    always_comb begin
      blocked[i] = 1'b0;
      for (int j = 0; j < NUM_CORES; j++) begin
        if (j < i && scOk[j] && sameWord[i*NUM_CORES + j]) blocked[i] = 1'b1;
      end
    end

    assign commit[i]        = scOk[i] && !blocked[i];
    assign ctl[i].commit    = commit[i];
    assign ctl[i].clrRes    = scReq[i];
    assign ctl[i].setRes    = lrReq[i] && !scReq[i];
    assign memWrEn[i]       = commit[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        respValid[i]  <= 1'b0;
        respStatus[i] <= 1'b0;
      end else begin
        respValid[i]  <= scReq[i];
        respStatus[i] <= scReq[i] && !commit[i];
      end
    end

    AST_COMMIT_NEEDS_RES: assert property (@(posedge clk) disable iff (!rstN)
      memWrEn[i] |-> (scReq[i] && scMatch[i])); // R2
    AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
      scReq[i] |=> (respValid[i] && (respStatus[i] == !$past(memWrEn[i])))); // R3
    AST_NO_STRAY_RESULT: assert property (@(posedge clk) disable iff (!rstN)
      !scReq[i] |=> (!respValid[i] && !respStatus[i])); // R3
    AST_WRITE_BEATS_SC: assert property (@(posedge clk) disable iff (!rstN)
      extHit[i] |-> !memWrEn[i]); // R7

    for (genvar k = i + 1; k < NUM_CORES; k++) begin : gPairs
      AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rstN)
        (memWrEn[i] && memWrEn[k]) |-> !sameWord[i*NUM_CORES + k]); // R8
    end
  end

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 32
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_CORES-1:0]        lrReq,
  input  logic [NUM_CORES-1:0]        scReq,
  input  logic [NUM_CORES*ADDR_W-1:0] reqAddr,
  input  logic                        wrValid,
  input  logic [ADDR_W-1:0]           wrAddr,
  output logic [NUM_CORES-1:0]        memWrEn,
  output logic [NUM_CORES-1:0]        respValid,
  output logic [NUM_CORES-1:0]        respStatus
);

  resStrobe_t [NUM_CORES-1:0]     ctl;
  logic [NUM_CORES-1:0]           scMatch;
  logic [NUM_CORES-1:0]           extHit;
  logic [NUM_CORES*NUM_CORES-1:0] sameWord;

  resv_datapath #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .reqAddr  (reqAddr),
    .wrValid  (wrValid),
    .wrAddr   (wrAddr),
    .ctl      (ctl),
    .scMatch  (scMatch),
    .extHit   (extHit),
    .sameWord (sameWord)
  );

  resv_control #(.NUM_CORES(NUM_CORES)) i_control (
    .clk        (clk),
    .rstN       (rstN),
    .lrReq      (lrReq),
    .scReq      (scReq),
    .scMatch    (scMatch),
    .extHit     (extHit),
    .sameWord   (sameWord),
    .ctl        (ctl),
    .memWrEn    (memWrEn),
    .respValid  (respValid),
    .respStatus (respStatus)
  );

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (respValid == '0)); // R1

endmodule

// File: tb/test_resv_monitor.sv
module test_resv_monitor;
  localparam int N  = 4;
  localparam int AW = 32;
  localparam logic [AW-1:0] A = 32'h0000_0100;
  localparam logic [AW-1:0] B = 32'h0000_0200;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN;
  logic [N-1:0]  lrReq, scReq;
  logic [N*AW-1:0] reqAddr;
  logic          wrValid;
  logic [AW-1:0] wrAddr;
  logic [N-1:0]  memWrEn, respValid, respStatus;

  resv_monitor #(.NUM_CORES(N), .ADDR_W(AW)) i_resv_monitor (
    .clk(clk), .rstN(rstN), .lrReq(lrReq), .scReq(scReq), .reqAddr(reqAddr),
    .wrValid(wrValid), .wrAddr(wrAddr), .memWrEn(memWrEn),
    .respValid(respValid), .respStatus(respStatus)
  );

  int checks = 0;
  int failures = 0;

  // Behavioural reference state
  bit            mv [N];
  logic [AW-3:0] mw [N];

  // Pending stimulus for the next step
  logic [N-1:0]  lrD, scD;
  logic [AW-1:0] aD [N];
  bit            wvD;
  logic [AW-1:0] waD;

  function automatic logic [AW-3:0] wordOf(input logic [AW-1:0] a);
    return a[AW-1:2];
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic lr(input int c, input logic [AW-1:0] a);
    lrD[c] = 1'b1; aD[c] = a;
  endtask

  task automatic sc(input int c, input logic [AW-1:0] a);
    scD[c] = 1'b1; aD[c] = a;
  endtask

  task automatic wr(input logic [AW-1:0] a);
    wvD = 1'b1; waD = a;
  endtask

  task automatic step(input string tag);
    logic [N-1:0] ok, cm;
    @(negedge clk);
    lrReq = lrD; scReq = scD; wrValid = wvD; wrAddr = waD;
    for (int c = 0; c < N; c++) reqAddr[c*AW +: AW] = aD[c];
    // expected commits
    for (int c = 0; c < N; c++)
      ok[c] = scD[c] && mv[c] && (mw[c] == wordOf(aD[c])) &&
              !(wvD && wordOf(waD) == mw[c]);
    for (int c = 0; c < N; c++) begin
      cm[c] = ok[c];
      for (int j = 0; j < c; j++)
        if (ok[j] && wordOf(aD[j]) == wordOf(aD[c])) cm[c] = 1'b0;
    end
    #1;
    check(tag, "memWrEn", memWrEn, cm);
    @(posedge clk);
    #1;
    check(tag, "respValid", respValid, scD);
    check(tag, "respStatus", respStatus, scD & ~cm);
    // update model
    for (int c = 0; c < N; c++) begin
      bit killed;
      killed = wvD && (wordOf(waD) == mw[c]);
      for (int j = 0; j < N; j++)
        if (cm[j] && wordOf(aD[j]) == mw[c]) killed = 1'b1;
      if (scD[c]) mv[c] = 1'b0;
      else if (lrD[c]) begin mv[c] = 1'b1; mw[c] = wordOf(aD[c]); end
      else if (killed) mv[c] = 1'b0;
    end
    lrD = '0; scD = '0; wvD = 1'b0; waD = '0;
    for (int c = 0; c < N; c++) aD[c] = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    lrD = '0; scD = '0; wvD = 1'b0; waD = '0;
    for (int c = 0; c < N; c++) begin aD[c] = '0; mv[c] = 1'b0; mw[c] = '0; end
    rstN = 1'b0; lrReq = '0; scReq = '0; reqAddr = '0; wrValid = 1'b0; wrAddr = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "respValid in reset", respValid, '0);
    check("R1", "memWrEn in reset", memWrEn, '0);
    @(negedge clk); rstN = 1'b1;

    // R1: no reservation after reset
    for (int c = 0; c < N; c++) sc(c, A);
    step("R1");

    // R2: success, any byte offset inside the word
    lr(0, A); step("R2");
    step("R2 idle");
    sc(0, A + 2); step("R2");
    // R5: second store-conditional fails
    sc(0, A); step("R5");

    // R4: no reservation, then wrong word
    sc(1, A); step("R4");
    lr(1, A); step("R4");
    sc(1, B); step("R4");
    sc(1, A); step("R4 R5");

    // R6: write to A kills every reservation on A only
    lr(0, A); lr(1, A); lr(2, B); step("R6");
    wr(A + 1); step("R6");
    sc(0, A); sc(1, A); sc(2, B); step("R6");
    lr(3, B); step("R6");
    wr(A); step("R6");
    sc(3, B); step("R6");

    // R7: write coincident with store-conditional
    lr(0, A); step("R7");
    sc(0, A); wr(A + 3); step("R7");

    // R8: same-cycle contention
    lr(1, A); lr(2, A); lr(3, B); step("R8");
    sc(1, A); sc(2, A); sc(3, B); step("R8");
    lr(0, B); lr(3, B); step("R8");
    sc(0, B); sc(3, B); step("R8");

    // R9: commit by one core kills peer reservation
    lr(0, A); lr(1, A); step("R9");
    sc(0, A); step("R9");
    sc(1, A); step("R9");

    // R10: replacement
    lr(0, A); step("R10");
    lr(0, B); step("R10");
    sc(0, A); step("R10");
    lr(0, A); step("R10");
    lr(0, B); step("R10");
    sc(0, B); step("R10");

    // R11: load-reserved ordered after same-cycle write / commit
    lr(1, A); wr(A); step("R11");
    sc(1, A); step("R11");
    lr(3, B); step("R11");
    lr(2, B); sc(3, B); step("R11");
    sc(2, B); step("R11");

    // R12: both strobes from one core
    lr(0, B); sc(0, B); step("R12");
    sc(0, B); step("R12");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule